// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This block paces the retries of a thread whose atomic compare-and-swap keeps losing. A pulse on `seq_start_i` opens a new atomic sequence and loads a backoff value of 1. Each reported failure makes the block ask a separate stall unit to hold the thread. When the stall unit signals completion, the backoff value doubles for the next retry. Doubling stops once the value has passed a fixed ceiling, and from then on the value stays where it is. A success pulse closes the sequence and returns the block to idle with the backoff value back at 1.

Two stall styles are supported, chosen per failure by `mode_iter_i`. In the single-request style the block sends one strobe whose amount is the backoff value shifted up by a fixed amount (times 128 cycles). In the iterative style it sends backoff+1 separate requests of 128 cycles each, and waits for the done handshake after every one. Only one request is ever outstanding, and a failure that arrives during a stall has no effect.

Top module: `backoff_retry_ctrl`

## Requirements
- R1: After reset, `stall_req_o` is 0 and `backoff_o` is 1. A `fail_i` pulse before any `seq_start_i` produces no request and leaves `backoff_o` at 1.
- R2: A `seq_start_i` pulse sets `backoff_o` to 1 on the next cycle. This holds even while a stall is in progress, and it abandons that stall.
- R3: In the single-request style (`mode_iter_i`=0), a `fail_i` pulse in an open sequence raises `stall_req_o` for exactly one cycle on the next clock, with `stall_amt_o` equal to `backoff_o` times 128 (shifted left by 7).
- R4: When `stall_done_i` completes the stall for a failure, `backoff_o` doubles on the next cycle if its value was 4096 or less.
- R5: Once `backoff_o` is above 4096 (that is, 8192), later failures do not change it. Every later single-request stall asks for 1048576 cycles.
- R6: In the iterative style (`mode_iter_i`=1), one failure produces exactly backoff+1 one-cycle requests, each with `stall_amt_o`=128. After the first request, each one follows the `stall_done_i` of the request before it by one cycle. The doubling happens only after the last done.
- R7: A `fail_i` pulse while a stall is outstanding produces no extra request and causes no extra doubling. `stall_req_o` is never high on two consecutive cycles.
- R8: A `success_i` pulse returns the block to idle with `backoff_o`=1. A later `fail_i` produces no request until a new `seq_start_i`.
- R9: `stall_amt_o` is 21 bits wide, so the largest request (8192 x 128) is carried without truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_start_i | input | 1 | Pulse: a new atomic sequence begins |
| fail_i | input | 1 | Pulse: the current attempt failed |
| success_i | input | 1 | Pulse: the atomic sequence succeeded |
| mode_iter_i | input | 1 | 0 = single scaled request, 1 = backoff+1 fixed chunks |
| stall_done_i | input | 1 | Stall unit finished the current request |
| stall_req_o | output | 1 | One-cycle strobe requesting a stall |
| stall_amt_o | output | 21 | Stall length in cycles, valid with the strobe |
| backoff_o | output | 14 | Current backoff value |

## Verification
A backoff register that goes wrong shows up on `backoff_o` in the cycle after the done that should have doubled it. It also shows up in `stall_amt_o` on the next failure, so the bench compares both against a table covering the whole climb to the ceiling and past it. A wrong chunk count in the iterative style shows up as one request too many or too few before the doubling. Such an error is caught within backoff+1 done handshakes. A broken guard on stalls in progress shows up as an extra strobe in the cycle after the ignored failure, or as a second doubling.

// File: rtl/backoff_pkg.sv
// Shared types for the backoff retry controller.
// Assumes: three-state sequencing is enough for one thread's retry loop.
package backoff_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_STALL = 2'd2
    } seq_state_e;
endpackage

// File: rtl/backoff_value_reg.sv
// Holds the backoff value: loads 1 on clear, doubles on grow while the
// value is at or below the ceiling, otherwise holds.
// Assumes: clear and grow are never asserted together by the sequencer.
module backoff_value_reg #(
    parameter int CEIL = 4096,
    parameter int BW   = $clog2(CEIL) + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          grow_i,
    output logic [BW-1:0] value_o
);
    localparam logic [BW-1:0] CEIL_V = BW'(CEIL);
    localparam logic [BW-1:0] ONE_V  = BW'(1);

    logic [BW-1:0] val_q;

    // Backoff register: reset/clear to one, double below the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= ONE_V;
        end else if (clear_i) begin
            val_q <= ONE_V;
        end else if (grow_i && (val_q <= CEIL_V)) begin
            val_q <= val_q << 1;
        end
    end

    assign value_o = val_q;

    assert_backoff_pow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(val_q));

    assert_ceiling_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (val_q > CEIL_V) && !clear_i |=> $stable(val_q));
endmodule

// File: rtl/stall_sequencer.sv
// Sequences one atomic retry loop: waits for failures, issues either one
// scaled stall request or backoff+1 fixed chunks, and waits on done.
// Assumes: the stall unit raises done no earlier than the cycle after a
// request strobe; done seen while the strobe is high is not counted.
module stall_sequencer
    import backoff_pkg::*;
#(
    parameter int BW    = 14,
    parameter int SH    = 7,
    parameter int CHUNK = 128,
    parameter int SW    = BW + SH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          fail_i,
    input  logic          success_i,
    input  logic          mode_iter_i,
    input  logic          done_i,
    input  logic [BW-1:0] backoff_i,
    output logic          clear_o,
    output logic          grow_o,
    output logic          req_o,
    output logic [SW-1:0] amt_o
);
    localparam int          CW      = BW + 1;
    localparam logic [CW-1:0] CNT_ONE = CW'(1);
    localparam logic [SW-1:0] CHUNK_V = SW'(CHUNK);

    seq_state_e    state_q;
    logic [CW-1:0] remain_q;
    logic          mode_q;
    logic          req_q;
    logic [SW-1:0] amt_q;
    logic          done_ok;

    // A done only counts while a stall is pending and no strobe is fresh.
    assign done_ok = (state_q == ST_STALL) && done_i && !req_q;

    // Main sequencing: start/success override, then failure and done handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            mode_q   <= 1'b0;
            req_q    <= 1'b0;
            amt_q    <= '0;
        end else begin
            req_q <= 1'b0;
            if (start_i) begin
                state_q  <= ST_ARMED;
                remain_q <= '0;
            end else if (success_i) begin
                state_q  <= ST_IDLE;
                remain_q <= '0;
            end else begin
                case (state_q)
                    ST_ARMED: begin
                        if (fail_i) begin
                            state_q <= ST_STALL;
                            mode_q  <= mode_iter_i;
                            req_q   <= 1'b1;
                            if (mode_iter_i) begin
                                amt_q    <= CHUNK_V;
                                remain_q <= {1'b0, backoff_i} + CNT_ONE;
                            end else begin
                                amt_q    <= {backoff_i, {SH{1'b0}}};
                                remain_q <= CNT_ONE;
                            end
                        end
                    end
                    ST_STALL: begin
                        if (done_ok) begin
                            if (remain_q > CNT_ONE) begin
                                remain_q <= remain_q - CNT_ONE;
                                req_q    <= 1'b1;
                            end else begin
                                remain_q <= '0;
                                state_q  <= ST_ARMED;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Control to the backoff register: clear on sequence boundaries,
    // grow when the final chunk of a stall is acknowledged.
    always_comb begin
        clear_o = start_i || success_i;
        grow_o  = !clear_o && done_ok && (remain_q == CNT_ONE);
    end

    assign req_o = req_q;
    assign amt_o = amt_q;

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

    assert_chunk_amount_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_q && mode_q |-> amt_q == CHUNK_V);

    assert_no_req_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !start_i |=> !req_q);
endmodule

// File: rtl/backoff_retry_ctrl.sv
// Top of the exponential backoff retry controller: joins the backoff
// register and the stall sequencer.
// Assumes: one atomic sequence per instance; pulses are single-cycle.
module backoff_retry_ctrl #(
    parameter int CEIL  = 4096,
    parameter int SH    = 7,
    parameter int CHUNK = 128,
    parameter int BW    = $clog2(CEIL) + 2,
    parameter int SW    = BW + SH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seq_start_i,
    input  logic          fail_i,
    input  logic          success_i,
    input  logic          mode_iter_i,
    input  logic          stall_done_i,
    output logic          stall_req_o,
    output logic [SW-1:0] stall_amt_o,
    output logic [BW-1:0] backoff_o
);
    logic          clear_w;
    logic          grow_w;
    logic [BW-1:0] value_w;

    backoff_value_reg #(.CEIL(CEIL), .BW(BW)) u_value (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_w),
        .grow_i  (grow_w),
        .value_o (value_w)
    );

    stall_sequencer #(.BW(BW), .SH(SH), .CHUNK(CHUNK), .SW(SW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (seq_start_i),
        .fail_i      (fail_i),
        .success_i   (success_i),
        .mode_iter_i (mode_iter_i),
        .done_i      (stall_done_i),
        .backoff_i   (value_w),
        .clear_o     (clear_w),
        .grow_o      (grow_w),
        .req_o       (stall_req_o),
        .amt_o       (stall_amt_o)
    );

    assign backoff_o = value_w;

    assert_start_loads_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start_i |=> backoff_o == BW'(1));
endmodule

// File: tb/tb_backoff_retry_ctrl.sv
module tb_backoff_retry_ctrl;
    localparam int BW = 14;
    localparam int SW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seq_start_i = 1'b0;
    logic          fail_i = 1'b0;
    logic          success_i = 1'b0;
    logic          mode_iter_i = 1'b0;
    logic          stall_done_i = 1'b0;
    logic          stall_req_o;
    logic [SW-1:0] stall_amt_o;
    logic [BW-1:0] backoff_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    backoff_retry_ctrl dut (.*);

    always #5 clk = ~clk;

    // Backoff seen before each failure and after its done, pause style.
    localparam int unsigned BO_PRE  [16] = '{1, 2, 4, 8, 16, 32, 64, 128, 256,
                                            512, 1024, 2048, 4096, 8192, 8192, 8192};
    localparam int unsigned BO_POST [16] = '{2, 4, 8, 16, 32, 64, 128, 256, 512,
                                            1024, 2048, 4096, 8192, 8192, 8192, 8192};

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        seq_start_i = 1'b1; step(); seq_start_i = 1'b0;
    endtask

    task automatic pulse_fail();
        fail_i = 1'b1; step(); fail_i = 1'b0;
    endtask

    task automatic pulse_done();
        stall_done_i = 1'b1; step(); stall_done_i = 1'b0;
    endtask

    // Count strobes over n cycles.
    task automatic count_reqs(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (stall_req_o) cnt++;
        end
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        total++; bad++;
        $display("FAIL watchdog R1 act=%0d exp=<100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state and failure before any sequence
        chk("R1 req", stall_req_o, 0);
        chk("R1 backoff", backoff_o, 1);
        pulse_fail();
        count_reqs(3, n);
        chk("R1 fail in idle reqs", n, 0);
        chk("R1 backoff unchanged", backoff_o, 1);

        // R3/R4/R5/R9: table walk, single-request style
        pulse_start();
        chk("R2 start loads one", backoff_o, 1);
        for (int i = 0; i < 16; i++) begin
            chk("R4 backoff before fail", backoff_o, BO_PRE[i]);
            pulse_fail();
            chk("R3 strobe", stall_req_o, 1);
            chk("R3 R9 amount", stall_amt_o, longint'(BO_PRE[i]) * 128);
            count_reqs(2, n);
            chk("R7 single strobe", n, 0);
            pulse_done();
            chk("R5 backoff after done", backoff_o, BO_POST[i]);
        end

        // R7: failure during a stall is ignored
        pulse_start();
        pulse_fail();
        chk("R7 first strobe", stall_req_o, 1);
        step();
        pulse_fail();
        chk("R7 no extra strobe", stall_req_o, 0);
        count_reqs(3, n);
        chk("R7 quiet during stall", n, 0);
        pulse_done();
        chk("R7 one doubling", backoff_o, 2);

        // R6: iterative style, backoff 2 -> 3 chunks
        mode_iter_i = 1'b1;
        pulse_fail();
        for (int k = 0; k < 3; k++) begin
            chk("R6 chunk strobe", stall_req_o, 1);
            chk("R6 chunk amount", stall_amt_o, 128);
            step();
            chk("R6 waits for done", stall_req_o, 0);
            chk("R6 no early doubling", backoff_o, 2);
            pulse_done();
        end
        chk("R6 no fourth chunk", stall_req_o, 0);
        chk("R6 doubled after last", backoff_o, 4);
        count_reqs(3, n);
        chk("R6 quiet after last", n, 0);

        // R6: backoff 4 -> 5 chunks, counted
        pulse_fail();
        n = 0;
        while (stall_req_o) begin
            n++;
            step();
            pulse_done();
        end
        chk("R6 five chunks", n, 5);
        chk("R6 backoff eight", backoff_o, 8);
        mode_iter_i = 1'b0;

        // R2: start during a stall abandons it
        pulse_fail();
        chk("R2 strobe before abort", stall_amt_o, 8 * 128);
        pulse_start();
        chk("R2 abort loads one", backoff_o, 1);
        pulse_done();
        chk("R2 stale done no grow", backoff_o, 1);
        pulse_fail();
        chk("R2 new sequence amt", stall_amt_o, 128);
        step();
        pulse_done();
        chk("R2 new sequence grow", backoff_o, 2);

        // R8: success returns to idle
        success_i = 1'b1; step(); success_i = 1'b0;
        chk("R8 backoff one", backoff_o, 1);
        pulse_fail();
        count_reqs(3, n);
        chk("R8 idle ignores fail", n + int'(stall_req_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule